// File: doc/BRIEF.md
# 64-bit Integer Operate Execution Unit

This unit decodes one 32-bit integer operate instruction and executes it on 64-bit operands. It receives the instruction word and the two values that the register file returned for the instruction's source fields. One clock later it presents the destination register index, a write enable and the 64-bit result. The operations are add, subtract-after-scale-by-four, shift left, arithmetic shift right, AND, OR, XOR and the low half of a multiply. The second operand comes either from a register or from an 8-bit unsigned literal held in the instruction.

Register index 31 is the constant-zero register. As a source it reads as zero, whatever the register file returns for it. As a destination it is written to nowhere. An instruction whose opcode and function pair is not in the supported set raises the illegal flag and writes nothing.

Top module: `iopx_unit`

## Requirements
- R1: While reset is asserted, and at the first output after it is released, `out_valid`, `wr_en` and `illegal` are 0.
- R2: The outputs belong to the instruction presented one clock earlier. `wr_idx` is bits [4:0] of that instruction, the destination field. The first source field is bits [25:21], the opcode is bits [31:26] and the function is bits [11:5].
- R3: Opcode 0x10 with function 0x20 writes a + b modulo 2^64. The encoding 0x42110401 adds r16 and r17 into r1.
- R4: When bit 12 is 1, b is the zero-extended 8-bit literal held in bits [20:13], and the register value for b is ignored. When bit 12 is 0, b is the register selected by bits [20:16]. The encoding 0x42009410 adds 4 to r16 and writes r16.
- R5: Opcode 0x10 with function 0x2B writes 4*a − b modulo 2^64.
- R6: Opcode 0x12 with function 0x39 writes a shifted left. Opcode 0x12 with function 0x3C writes a shifted right and filled with copies of a's sign bit. Each shift uses only b[5:0] as its amount.
- R7: Opcode 0x11 writes a AND b for function 0x00, a OR b for function 0x20, and a XOR b for function 0x40.
- R8: Opcode 0x13 with function 0x20 writes the low 64 bits of a × b.
- R9: A source field equal to 31 supplies the value zero, whatever the register value presented for it.
- R10: A legal instruction whose destination field is 31 gives `wr_en` = 0 and `illegal` = 0, with `out_valid` = 1.
- R11: Any opcode and function pair outside those listed in R3, R5, R6, R7 and R8 gives `illegal` = 1 and `wr_en` = 0.
- R12: A cycle with `in_valid` = 0 gives `out_valid`, `wr_en` and `illegal` all 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| ra_val | input | 64 | Register value for the first source field |
| rb_val | input | 64 | Register value for the second source field |
| out_valid | output | 1 | Registered result slot is occupied |
| wr_en | output | 1 | Write the result to `wr_idx` |
| wr_idx | output | 5 | Destination register index |
| result | output | 64 | Operation result |
| illegal | output | 1 | Opcode and function pair not supported |

## Verification
Every operation is driven with operand pairs that separate the operations from one another: zero, all ones, a lone sign bit, alternating bit patterns and values from an LFSR. Each pair is applied in both register form and literal form, so an operation that takes b from the wrong source gives a different result. Shift amounts run over 0 to 63 and also appear with upper bits set in b, which shows whether the amount is masked and whether the right shift fills with the sign bit. A sweep over every function code of opcodes 0x0F through 0x14 separates legal pairs from illegal ones. Source and destination fields of 31, with non-zero register values presented for them, show the zero-register behaviour.

// File: rtl/iopx_pkg.sv
package iopx_pkg;
  typedef enum logic [2:0] {
    OP_ADD, OP_S4SUB, OP_AND, OP_OR, OP_XOR, OP_SLL, OP_SRA, OP_MUL
  } alu_op_e;

  localparam int REG_IDX_W = 5;
  localparam int LIT_W     = 8;
  localparam logic [REG_IDX_W-1:0] ZERO_REG = 5'd31;

  typedef struct packed {
    alu_op_e              op;
    logic                 legal;
    logic                 use_lit;
    logic [REG_IDX_W-1:0] src_a;
    logic [REG_IDX_W-1:0] src_b;
    logic [REG_IDX_W-1:0] dst;
    logic [LIT_W-1:0]     lit;
  } dec_t;
endpackage

// File: rtl/iopx_decode.sv
module iopx_decode
  import iopx_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic [5:0] opc;
  logic [6:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[11:5];

  always_comb begin
    dec.src_a   = instr[25:21];
    dec.src_b   = instr[20:16];
    dec.dst     = instr[4:0];
    dec.use_lit = instr[12];
    dec.lit     = instr[20:13];
    dec.op      = OP_ADD;
    dec.legal   = 1'b1;
    unique case ({opc, fn})
      {6'h10, 7'h20}: dec.op = OP_ADD;
      {6'h10, 7'h2B}: dec.op = OP_S4SUB;
      {6'h11, 7'h00}: dec.op = OP_AND;
      {6'h11, 7'h20}: dec.op = OP_OR;
      {6'h11, 7'h40}: dec.op = OP_XOR;
      {6'h12, 7'h39}: dec.op = OP_SLL;
      {6'h12, 7'h3C}: dec.op = OP_SRA;
      {6'h13, 7'h20}: dec.op = OP_MUL;
      default:        dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/iopx_alu.sv
module iopx_alu
  import iopx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int SH_W = $clog2(XLEN);

  function automatic logic [XLEN-1:0] f_s4sub(input logic [XLEN-1:0] x, input logic [XLEN-1:0] z);
    return (x << 2) - z;
  endfunction

  function automatic logic [XLEN-1:0] f_sll(input logic [XLEN-1:0] x, input logic [SH_W-1:0] s);
    return x << s;
  endfunction

  function automatic logic [XLEN-1:0] f_sra(input logic [XLEN-1:0] x, input logic [SH_W-1:0] s);
    return XLEN'($signed(x) >>> s);
  endfunction

  function automatic logic [XLEN-1:0] f_mul_lo(input logic [XLEN-1:0] x, input logic [XLEN-1:0] z);
    return x * z;
  endfunction

  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:   y = a + b;
      OP_S4SUB: y = f_s4sub(a, b);
      OP_AND:   y = a & b;
      OP_OR:    y = a | b;
      OP_XOR:   y = a ^ b;
      OP_SLL:   y = f_sll(a, shamt);
      OP_SRA:   y = f_sra(a, shamt);
      OP_MUL:   y = f_mul_lo(a, b);
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/iopx_unit.sv
module iopx_unit
  import iopx_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic            out_valid,
  output logic            wr_en,
  output logic [4:0]      wr_idx,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  dec_t            dec;
  logic [XLEN-1:0] opnd_a, opnd_b, alu_y;
  logic            dst_is_zero_reg;
  logic            dec_illegal;

  iopx_decode u_dec (.instr(instr), .dec(dec));

  assign opnd_a = (dec.src_a == ZERO_REG) ? '0 : ra_val;
  assign opnd_b = dec.use_lit ? XLEN'(dec.lit)
                : ((dec.src_b == ZERO_REG) ? '0 : rb_val);

  iopx_alu #(.XLEN(XLEN)) u_alu (.op(dec.op), .a(opnd_a), .b(opnd_b), .y(alu_y));

  assign dst_is_zero_reg = (dec.dst == ZERO_REG);
  assign dec_illegal     = ~dec.legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
      wr_idx    <= '0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & dec.legal & ~dst_is_zero_reg;
      illegal   <= in_valid & dec_illegal;
      wr_idx    <= dec.dst;
      result    <= alu_y;
    end
  end

  assert_wen_needs_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);
  assert_idle_gives_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !illegal));
  assert_one_cycle_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_illegal_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en);
  assert_zero_dst_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wr_idx == ZERO_REG) |-> !wr_en);
  assert_illegal_flag_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_illegal) |=> (illegal && out_valid));
endmodule

// File: tb/sim_iopx_unit.sv
module sim_iopx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] ra_val, rb_val;
  logic        out_valid, wr_en, illegal;
  logic [4:0]  wr_idx;
  logic [63:0] result;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  iopx_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .ra_val(ra_val), .rb_val(rb_val), .out_valid(out_valid), .wr_en(wr_en),
    .wr_idx(wr_idx), .result(result), .illegal(illegal));

  // kinds: 0 add,1 s4sub,2 and,3 or,4 xor,5 sll,6 sra,7 mul
  function automatic logic [12:0] kind_code(input int k);
    case (k)
      0: return {6'h10, 7'h20};
      1: return {6'h10, 7'h2B};
      2: return {6'h11, 7'h00};
      3: return {6'h11, 7'h20};
      4: return {6'h11, 7'h40};
      5: return {6'h12, 7'h39};
      6: return {6'h12, 7'h3C};
      default: return {6'h13, 7'h20};
    endcase
  endfunction

  function automatic string kind_req(input int k);
    case (k)
      0: return "R3";
      1: return "R5";
      2, 3, 4: return "R7";
      5, 6: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [63:0] model(input int k, input logic [63:0] a, input logic [63:0] b);
    int s;
    logic [63:0] r;
    s = int'(b % 64);
    case (k)
      0: r = a + b;
      1: r = a + a + a + a - b;
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = a * (64'd1 << s);
      6: begin
        r = a / (64'd1 << s);
        if (a[63]) r = r | ~({64{1'b1}} >> s);
      end
      default: r = a * b;
    endcase
    return r;
  endfunction

  function automatic bit is_legal(input logic [5:0] o, input logic [6:0] f);
    for (int k = 0; k < 8; k++) if (kind_code(k) == {o, f}) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] enc(input logic [5:0] o, input logic [6:0] f,
      input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] rc,
      input bit lit, input logic [7:0] lv);
    if (lit) return {o, ra, lv, 1'b1, f, rc};
    return {o, ra, rb, 3'b000, 1'b0, f, rc};
  endfunction

  task automatic apply(input string req, input logic [31:0] ins, input logic [63:0] a,
      input logic [63:0] b, input bit e_wen, input bit e_ill, input logic [4:0] e_idx,
      input bit chk_res, input logic [63:0] e_res);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; ra_val = a; rb_val = b;
    @(negedge clk);
    nvec++;
    if (out_valid !== 1'b1 || wr_en !== e_wen || illegal !== e_ill || wr_idx !== e_idx
        || (chk_res && result !== e_res)) begin
      nfail++;
      $display("FAIL %s instr=%h: v=%b we=%b ill=%b idx=%0d res=%h expected v=1 we=%b ill=%b idx=%0d res=%h",
        req, ins, out_valid, wr_en, illegal, wr_idx, result, e_wen, e_ill, e_idx, e_res);
    end
    in_valid = 1'b0;
  endtask

  task automatic check_idle(input string req);
    nvec++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0 || illegal !== 1'b0) begin
      nfail++;
      $display("FAIL %s idle: v=%b we=%b ill=%b expected 0 0 0", req, out_valid, wr_en, illegal);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [8];
    logic [63:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b1; instr = 32'h42110401; ra_val = 64'd5; rb_val = 64'd6;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check_idle("R1");

    // R3 / R2 given encoding: add r16,r17 -> r1
    apply("R3", 32'h42110401, 64'd100, 64'd23, 1, 0, 5'd1, 1, 64'd123);
    // R4 given literal encoding: r16 + 4 -> r16, rb value ignored
    apply("R4", 32'h42009410, 64'd10, 64'hFFFF, 1, 0, 5'd16, 1, 64'd14);
    @(negedge clk);
    check_idle("R12");

    pats[0] = 64'd0; pats[1] = '1; pats[2] = 64'h8000_0000_0000_0000;
    pats[3] = 64'hAAAA_AAAA_5555_5555; pats[4] = 64'd1; pats[5] = 64'h7FFF_FFFF_FFFF_FFFF;
    pats[6] = 64'h0123_4567_89AB_CDEF; pats[7] = 64'hF0F0_0F0F_3C3C_C3C3;
    lfsr = 64'hACE1_2345_6789_BEEF;
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [63:0] bb;
          bb = (k == 5 || k == 6) ? (pats[j] ^ 64'(j * 9)) : pats[j];
          apply(kind_req(k), enc(kind_code(k)[12:7], kind_code(k)[6:0], 5'd3, 5'd7, 5'd9, 0, 8'd0),
                pats[i], bb, 1, 0, 5'd9, 1, model(k, pats[i], bb));
        end
        // literal form, rb value must be ignored (R4)
        for (int l = 0; l < 4; l++) begin
          logic [7:0] lv;
          lv = lfsr[7:0] ^ 8'(l * 37);
          lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
          apply("R4", enc(kind_code(k)[12:7], kind_code(k)[6:0], 5'd4, 5'd0, 5'd12, 1, lv),
                pats[i], lfsr, 1, 0, 5'd12, 1, model(k, pats[i], 64'(lv)));
        end
      end
      // random register pairs
      for (int r = 0; r < 24; r++) begin
        logic [63:0] a;
        a = lfsr;
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        apply(kind_req(k), enc(kind_code(k)[12:7], kind_code(k)[6:0], 5'd1, 5'd2, 5'd30, 0, 8'd0),
              a, lfsr, 1, 0, 5'd30, 1, model(k, a, lfsr));
      end
    end

    // R6 every shift amount, upper bits of b set
    for (int s = 0; s < 64; s++) begin
      logic [63:0] bb;
      bb = 64'(s) | 64'hFFFF_FF00_0000_0C0;
      apply("R6", enc(6'h12, 7'h3C, 5'd5, 5'd6, 5'd7, 0, 8'd0), 64'h8765_4321_0FED_CBA9, bb,
            1, 0, 5'd7, 1, model(6, 64'h8765_4321_0FED_CBA9, 64'(s)));
      apply("R6", enc(6'h12, 7'h39, 5'd5, 5'd6, 5'd7, 0, 8'd0), 64'h8765_4321_0FED_CBA9, bb,
            1, 0, 5'd7, 1, model(5, 64'h8765_4321_0FED_CBA9, 64'(s)));
    end

    // R9 zero register as a source
    apply("R9", enc(6'h10, 7'h20, 5'd31, 5'd2, 5'd3, 0, 8'd0), 64'hDEAD, 64'd7, 1, 0, 5'd3, 1, 64'd7);
    apply("R9", enc(6'h11, 7'h20, 5'd2, 5'd31, 5'd3, 0, 8'd0), 64'd9, 64'hBEEF, 1, 0, 5'd3, 1, 64'd9);
    apply("R9", enc(6'h13, 7'h20, 5'd31, 5'd31, 5'd3, 0, 8'd0), 64'd11, 64'd13, 1, 0, 5'd3, 1, 64'd0);
    apply("R9", enc(6'h10, 7'h20, 5'd31, 5'd0, 5'd3, 1, 8'd200), 64'd77, 64'd1, 1, 0, 5'd3, 1, 64'd200);

    // R10 destination zero register
    apply("R10", enc(6'h10, 7'h20, 5'd1, 5'd2, 5'd31, 0, 8'd0), 64'd1, 64'd2, 0, 0, 5'd31, 0, 64'd0);
    apply("R10", enc(6'h12, 7'h39, 5'd1, 5'd2, 5'd31, 1, 8'd3), 64'd1, 64'd2, 0, 0, 5'd31, 0, 64'd0);

    // R11 sweep of opcodes 0x0F..0x14 over all function codes
    for (int o = 15; o <= 20; o++) begin
      for (int f = 0; f < 128; f++) begin
        bit lg;
        lg = is_legal(6'(o), 7'(f));
        apply(lg ? "R2" : "R11", enc(6'(o), 7'(f), 5'd8, 5'd9, 5'd10, 0, 8'd0), 64'd3, 64'd5,
              lg, !lg, 5'd10, 0, 64'd0);
      end
    end
    apply("R11", enc(6'h00, 7'h20, 5'd8, 5'd9, 5'd10, 0, 8'd0), 64'd3, 64'd5, 0, 1, 5'd10, 0, 64'd0);
    apply("R11", enc(6'h3F, 7'h20, 5'd8, 5'd9, 5'd10, 1, 8'd1), 64'd3, 64'd5, 0, 1, 5'd10, 0, 64'd0);
    @(negedge clk);
    check_idle("R12");

    // R1 reset mid-stream
    @(negedge clk);
    in_valid = 1'b1; instr = 32'h42110401; rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check_idle("R12");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule